// File: doc/BRIEF.md
# SONET A1/A2 Frame Aligner

This block sits behind a 1:4 serial-to-parallel converter on the receive side of a SONET/SDH line interface. Each clock it accepts a 4-bit nibble whose bit 0 was received first. It searches the serial stream at every bit position for the framing word: three A1 bytes (0xF6) followed at once by one A2 byte (0x28). When it finds this word it records the bit position, and it then shifts the outgoing nibble bus so that every byte starts at bit 0 of a nibble.

Framing is accepted only after the word has appeared three times, each occurrence exactly one frame interval after the one before. When that happens the block raises an in-frame flag and a four-cycle sync pulse. While in frame, a framing word seen anywhere other than the expected position is ignored. Only a run of consecutive misses at the expected position sends the block back to searching. An enable input pauses the search and keeps the current boundary.

The controller has three states. HUNT scans all four bit offsets every clock. VERIFY counts repeats at the recorded offset, one check per frame interval. LOCKED watches the expected position and counts misses. The transitions are:

- HUNT→VERIFY: the framing word is seen at any offset.
- VERIFY→VERIFY: a repeat arrives on schedule and fewer than three occurrences have been seen so far.
- VERIFY→LOCKED: the third on-schedule occurrence arrives.
- VERIFY→HUNT: a scheduled check finds no framing word.
- LOCKED→LOCKED: a scheduled check finds the word, which clears the miss count, or finds a miss that is still below the limit.
- LOCKED→HUNT: the miss limit is reached.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While reset is high and on the first cycle after it, `dout_o` is 0 and both `sync_o` and `in_frame_o` are 0.
- R2: The framing word 0xF6F6F628 is taken most significant bit first in time, and `din_i[0]` is the earliest bit of a nibble. The word is found at any of the four bit offsets within a nibble.
- R3: `in_frame_o` goes high at the clock edge that accepts the third on-schedule occurrence of the framing word. Occurrences are spaced `FRAME_LEN` nibbles apart. In VERIFY, a missing word at the scheduled position returns the block to HUNT, and the occurrence count starts again.
- R4: `dout_o` is registered with one cycle of latency and uses the recorded offset. After lock, `dout_o[0]` is the first bit of a byte, and the nibble shown with the first sync cycle is the one that carries the first bit after A2.
- R5: On lock, `sync_o` is high for exactly `SYNC_LEN` (4) cycles, starting one edge after `in_frame_o` rises.
- R6: In LOCKED, a framing word at any position other than the scheduled one changes neither the state nor the offset.
- R7: While `en_i` is low, the state, offset and frame timer hold. No lock can be reached and no new sync pulse can start, while `dout_o` keeps the recorded alignment.
- R8: In LOCKED, `MISS_LIMIT` (4) consecutive scheduled misses drop `in_frame_o` and restart HUNT. A scheduled hit clears the miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Search and align enable; low freezes the framing state |
| din_i | input | 4 | Raw nibble, bit 0 earliest in time |
| dout_o | output | 4 | Realigned nibble, bit 0 earliest in time |
| sync_o | output | 1 | Frame sync pulse on lock |
| in_frame_o | output | 1 | High while in the LOCKED state |

## Verification
The assertions assume three things about the inputs. First, reset is held for at least one edge before checking starts. Second, `en_i` is a level that changes only between edges. Third, two lock events are never closer than `SYNC_LEN + 1` cycles, which holds whenever `FRAME_LEN` is larger than that. The stimulus meets these conditions in the following ways:

- It drives every input just after a rising edge.
- It uses a shortened frame of 64 nibbles, so locks are always several frames apart.
- It builds every stream from whole 256-bit frames, each carrying the framing word at its start, a look-alike inside the payload, or neither.
- It changes the bit offset only by inserting single bits between frames.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fa_state_e;

    localparam int          FA_PAT_W   = 32;
    localparam logic [31:0] FA_PATTERN = 32'hF6F6_F628;
endpackage

// File: rtl/fa_window.sv
// Bit history and framing word match at every offset within the newest nibble.
module fa_window #(
    parameter int NIB_W = 4,
    parameter int PAT_W = fa_pkg::FA_PAT_W,
    localparam int WIN_W  = PAT_W + NIB_W - 1,
    localparam int HIST_W = PAT_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] din,
    output logic [WIN_W-1:0] win,
    output logic [NIB_W-1:0] hit
);
    logic [HIST_W-1:0] hist_q;
    logic [NIB_W-1:0]  fresh;

    // newest bit lands at win[0]; din[0] is earliest so it sits highest
    for (genvar i = 0; i < NIB_W; i++) begin : g_rev
        assign fresh[NIB_W-1-i] = din[i];
    end

    assign win = {hist_q, fresh};

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= win[HIST_W-1:0];
    end

    // hit[j]: word ends j bits before the newest bit
    for (genvar j = 0; j < NIB_W; j++) begin : g_cmp
        assign hit[j] = (win[j+PAT_W-1 -: PAT_W] == fa_pkg::FA_PATTERN);
    end
endmodule

// File: rtl/fa_ctrl.sv
// Framing state machine: HUNT, VERIFY, LOCKED.
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int NIB_W      = 4,
    parameter int FRAME_LEN  = 9720,
    parameter int CONFIRM    = 3,
    parameter int MISS_LIMIT = 4,
    localparam int OFF_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1,
    localparam int TMR_W  = $clog2(FRAME_LEN),
    localparam int CNT_W  = $clog2(CONFIRM + 1),
    localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [NIB_W-1:0] hit,
    output logic [OFF_W-1:0] off,
    output logic             locked,
    output logic             fire
);
    fa_state_e         st_q, st_n;
    logic [OFF_W-1:0]  off_q, off_n;
    logic [TMR_W-1:0]  tmr_q, tmr_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic [OFF_W-1:0]  hunt_off;
    logic              hunt_any;
    logic              due;
    logic              sched_hit;

    // lowest offset wins if several match
    always_comb begin
        hunt_off = '0;
        for (int j = NIB_W - 1; j >= 0; j--) begin
            if (hit[j]) hunt_off = OFF_W'(j);
        end
    end

    assign hunt_any  = |hit;
    assign due       = (tmr_q == TMR_W'(FRAME_LEN - 1));
    assign sched_hit = hit[off_q];

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            off_q  <= '0;
            tmr_q  <= '0;
            cnt_q  <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_n;
            off_q  <= off_n;
            tmr_q  <= tmr_n;
            cnt_q  <= cnt_n;
            miss_q <= miss_n;
        end
    end

    // next-state logic
    always_comb begin
        st_n   = st_q;
        off_n  = off_q;
        tmr_n  = tmr_q;
        cnt_n  = cnt_q;
        miss_n = miss_q;
        fire   = 1'b0;
        if (en) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (hunt_any) begin
                        off_n = hunt_off;
                        cnt_n = CNT_W'(1);
                        tmr_n = '0;
                        st_n  = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (due) begin
                        tmr_n = '0;
                        if (sched_hit) begin
                            if (cnt_q == CNT_W'(CONFIRM - 1)) begin
                                st_n   = ST_LOCKED;
                                miss_n = '0;
                                fire   = 1'b1;
                            end else begin
                                cnt_n = cnt_q + 1'b1;
                            end
                        end else begin
                            st_n = ST_HUNT;
                        end
                    end else begin
                        tmr_n = tmr_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (due) begin
                        tmr_n = '0;
                        if (sched_hit) begin
                            miss_n = '0;
                        end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                            st_n = ST_HUNT;
                        end else begin
                            miss_n = miss_q + 1'b1;
                        end
                    end else begin
                        tmr_n = tmr_q + 1'b1;
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    // output process
    always_comb begin
        locked = (st_q == ST_LOCKED);
        off    = off_q;
    end
endmodule

// File: rtl/fa_align.sv
// Output barrel select and delayed sync pulse.
module fa_align #(
    parameter int NIB_W    = 4,
    parameter int WIN_W    = 35,
    parameter int SYNC_LEN = 4,
    localparam int OFF_W = (NIB_W > 1) ? $clog2(NIB_W) : 1,
    localparam int IDX_W = $clog2(WIN_W),
    localparam int SC_W  = $clog2(SYNC_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] win,
    input  logic [OFF_W-1:0] off,
    input  logic             fire,
    output logic [NIB_W-1:0] dout,
    output logic             sync
);
    logic [NIB_W-1:0] dout_n;
    logic [NIB_W-1:0] dout_q;
    logic [SC_W-1:0]  sc_q;

    always_comb begin
        for (int i = 0; i < NIB_W; i++) begin
            dout_n[i] = win[IDX_W'(off) + IDX_W'(NIB_W - 1 - i)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            sc_q   <= '0;
        end else begin
            dout_q <= dout_n;
            if (fire)              sc_q <= SC_W'(SYNC_LEN + 1);
            else if (sc_q != '0)   sc_q <= sc_q - 1'b1;
        end
    end

    // one idle count delays the pulse onto the first nibble after A2
    assign sync = (sc_q != '0) && (sc_q <= SC_W'(SYNC_LEN));
    assign dout = dout_q;
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
    parameter int NIB_W      = 4,
    parameter int FRAME_LEN  = 9720,
    parameter int CONFIRM    = 3,
    parameter int MISS_LIMIT = 4,
    parameter int SYNC_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [NIB_W-1:0] din_i,
    output logic [NIB_W-1:0] dout_o,
    output logic             sync_o,
    output logic             in_frame_o
);
    localparam int PAT_W = fa_pkg::FA_PAT_W;
    localparam int WIN_W = PAT_W + NIB_W - 1;
    localparam int OFF_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;

    logic [WIN_W-1:0] win;
    logic [NIB_W-1:0] hit;
    logic [OFF_W-1:0] off;
    logic             fire;

    fa_window #(.NIB_W(NIB_W), .PAT_W(PAT_W)) u_win (
        .clk (clk),
        .rst (rst),
        .din (din_i),
        .win (win),
        .hit (hit)
    );

    fa_ctrl #(
        .NIB_W(NIB_W), .FRAME_LEN(FRAME_LEN),
        .CONFIRM(CONFIRM), .MISS_LIMIT(MISS_LIMIT)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en_i),
        .hit    (hit),
        .off    (off),
        .locked (in_frame_o),
        .fire   (fire)
    );

    fa_align #(.NIB_W(NIB_W), .WIN_W(WIN_W), .SYNC_LEN(SYNC_LEN)) u_align (
        .clk  (clk),
        .rst  (rst),
        .win  (win),
        .off  (off),
        .fire (fire),
        .dout (dout_o),
        .sync (sync_o)
    );
endmodule

// File: rtl/sonet_frame_aligner_chk.sv
module sonet_frame_aligner_chk #(
    parameter int SYNC_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic sync_o,
    input logic in_frame_o
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (sync_o) run_q <= run_q + 8'd1;
        else             run_q <= '0;
    end

    // R1: outputs quiet right after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sync_o && !in_frame_o));

    // R3: entering frame needs the enable
    p_lock_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame_o) |-> $past(en_i));

    // R5: pulse starts one edge after lock, while still in frame
    p_sync_after_lock_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> (in_frame_o && $past(in_frame_o)));

    // R5: pulse never runs beyond its length
    p_sync_max_r5: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> (run_q < 8'(SYNC_LEN)));

    // R5: pulse ends after exactly its length
    p_sync_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_o) |-> (run_q == 8'(SYNC_LEN)));

    // R7: frozen state while enable is low
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(in_frame_o));

    // R7: no new pulse started without enable
    p_sync_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> $past(en_i, 2));

    // R8: leaving frame only happens on an enabled cycle
    p_drop_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(in_frame_o) |-> $past(en_i));
endmodule

bind sonet_frame_aligner sonet_frame_aligner_chk #(.SYNC_LEN(SYNC_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .sync_o     (sync_o),
    .in_frame_o (in_frame_o)
);

// File: tb/sim_sonet_frame_aligner.sv
`timescale 1ns/1ps
module sim_sonet_frame_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int FL         = 64;
    localparam logic [31:0] PAT = 32'hF6F6_F628;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] dout;
    logic       sync;
    logic       inf;

    sonet_frame_aligner #(.FRAME_LEN(FL)) u0 (
        .clk(clk), .rst(rst), .en_i(en), .din_i(din),
        .dout_o(dout), .sync_o(sync), .in_frame_o(inf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int sync_hi = 0;
    bit seen_drop = 0;

    // behavioural reference
    bit   q[$];
    bit   pend[$];
    int   m_st, m_off, m_tmr, m_cnt, m_miss, m_sc;
    logic [3:0] m_dout;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(int j);
        int e = q.size() - 1 - j;
        for (int k = 0; k < 32; k++)
            if (q[e - 31 + k] != PAT[31 - k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < 31; i++) q.push_back(1'b0);
        m_st = 0; m_off = 0; m_tmr = 0; m_cnt = 0; m_miss = 0; m_sc = 0;
        m_dout = 4'd0;
    endtask

    task automatic model_edge(logic [3:0] d, bit e);
        int n;
        int hj;
        bit fire;
        for (int i = 0; i < 4; i++) q.push_back(d[i]);
        n = q.size();
        for (int i = 0; i < 4; i++) m_dout[i] = q[n - 1 - m_off - 3 + i];
        fire = 1'b0;
        if (e) begin
            if (m_st == 0) begin
                hj = -1;
                for (int j = 3; j >= 0; j--) if (m_hit(j)) hj = j;
                if (hj >= 0) begin
                    m_off = hj; m_cnt = 1; m_tmr = 0; m_st = 1;
                end
            end else if (m_st == 1) begin
                if (m_tmr == FL - 1) begin
                    m_tmr = 0;
                    if (m_hit(m_off)) begin
                        if (m_cnt == 2) begin m_st = 2; m_miss = 0; fire = 1'b1; end
                        else m_cnt++;
                    end else m_st = 0;
                end else m_tmr++;
            end else begin
                if (m_tmr == FL - 1) begin
                    m_tmr = 0;
                    if (m_hit(m_off)) m_miss = 0;
                    else if (m_miss == 3) m_st = 0;
                    else m_miss++;
                end else m_tmr++;
            end
        end
        if (fire) m_sc = 5;
        else if (m_sc > 0) m_sc--;
        while (q.size() > 40) void'(q.pop_front());
    endtask

    task automatic step(bit e);
        logic [3:0] nib;
        for (int i = 0; i < 4; i++) nib[i] = pend.pop_front();
        din = nib;
        en  = e;
        @(posedge clk);
        #1;
        model_edge(nib, e);
        check("R4 aligned dout", int'(dout), int'(m_dout));
        check("R5 sync pulse", int'(sync), int'(m_sc >= 1 && m_sc <= 4));
        check("R3 in_frame", int'(inf), int'(m_st == 2));
        if (sync) sync_hi++;
        if (!inf && e) seen_drop = seen_drop;
    endtask

    task automatic flush(bit e);
        while (pend.size() >= 4) step(e);
    endtask

    task automatic push_rand(int nb);
        for (int i = 0; i < nb; i++) pend.push_back(1'($urandom_range(0, 1)));
    endtask

    task automatic push_pat();
        for (int k = 0; k < 32; k++) pend.push_back(PAT[31 - k]);
    endtask

    // one frame of FL nibbles = 256 bits
    task automatic push_frame(bit with_pat, bit fake);
        if (with_pat) push_pat(); else push_rand(32);
        if (fake) begin push_rand(100); push_pat(); push_rand(92); end
        else push_rand(224);
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; din = 4'd0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset dout", int'(dout), 0);
        check("R1 reset sync", int'(sync), 0);
        check("R1 reset in_frame", int'(inf), 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        pend.delete();
        sync_hi = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R2: lock at every bit offset; R5 pulse length
        for (int o = 0; o < 4; o++) begin
            do_reset();
            push_rand(o);
            for (int f = 0; f < 4; f++) push_frame(1'b1, 1'b0);
            flush(1'b1);
            check($sformatf("R2 lock at offset %0d", o), int'(inf), 1);
            check("R5 sync cycles after lock", sync_hi, 4);
        end

        // R6: look-alike words inside payload ignored while locked
        for (int f = 0; f < 2; f++) push_frame(1'b1, 1'b1);
        flush(1'b1);
        check("R6 guard keeps lock", int'(inf), 1);

        // R7: freeze while enable low, stream slips by one bit
        pend.push_back(1'b0);
        for (int f = 0; f < 2; f++) push_frame(1'b1, 1'b0);
        flush(1'b0);
        check("R7 frozen lock held", int'(inf), 1);
        check("R7 no sync while frozen", sync_hi, 4);

        // R8: scheduled misses drop lock, then relock at new offset
        seen_drop = 1'b0;
        for (int f = 0; f < 10; f++) begin
            push_frame(1'b1, 1'b0);
            while (pend.size() >= 4) begin
                step(1'b1);
                if (!inf) seen_drop = 1'b1;
            end
        end
        check("R8 lock dropped after misses", int'(seen_drop), 1);
        check("R8 relocked at new offset", int'(inf), 1);
        check("R5 second sync pulse", sync_hi, 8);

        // R3: a gap during VERIFY restarts the count
        do_reset();
        push_frame(1'b1, 1'b0);
        push_frame(1'b0, 1'b0);
        push_frame(1'b1, 1'b0);
        push_frame(1'b1, 1'b0);
        flush(1'b1);
        check("R3 gap restarts count", int'(inf), 0);
        push_frame(1'b1, 1'b0);
        flush(1'b1);
        check("R3 third scheduled word locks", int'(inf), 1);

        // R7: enable low in HUNT prevents any lock
        do_reset();
        for (int f = 0; f < 4; f++) push_frame(1'b1, 1'b0);
        flush(1'b0);
        check("R7 no lock while disabled", int'(inf), 0);
        check("R7 no sync while disabled", sync_hi, 0);

        summary();
        $finish;
    end
endmodule